// File: doc/BRIEF.md
# Raw NAND Flash Bus Controller with Programmable Cycle Timing

This block lets a host CPU drive an 8-bit raw NAND flash device through a small set of 32-bit memory-mapped registers. Software writes the command register to run a command-latch cycle and the address register to run an address-latch cycle. It reads or writes the data register to run one data cycle that moves a single byte. The controller turns each of these accesses into one bus cycle on the flash pins.

Every bus cycle has three phases: setup, strobe width and hold. Each phase length comes from a 4-bit clock count in a timing register. Reads and writes have separate sets of counts. After the hold phase the controller stays busy for a programmable ready-wait count. While it is busy, register accesses are stalled through a request/acknowledge handshake. The controller also provides chip-enable forcing, a synchronised ready/busy status bit, a ready event and a cycle-done event with enable and clear registers, and a software reset.

The host holds `req_i` with the address, direction and write data until `ack_o` is high at a rising clock edge; read data is valid on `rdata_o` while `ack_o` is high.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset the flash pins are idle (`nand_ce_no`=1, `nand_cle_o`=0, `nand_ale_o`=0, `nand_we_no`=1, `nand_re_no`=1, `nand_dq_oe_o`=0), `irq_o` is 0, and the config, event-enable, event-status and timing registers read 0.
- R2: Registers are addressed by word index: data 0, address 1, command 2, control 4, config 5, status 6, event status 7, event enable 8, event clear 10, timing 11. Config keeps bits [5:0], event enable keeps bits [1:0], timing keeps all 32 bits, and each reads back what was written. Indices 3, 9 and 12 to 15 read 0.
- R3: A write to the command register runs one bus cycle with CLE high, ALE low, the write strobe `nand_we_no` pulsed low, and bits [7:0] of the written word driven on `nand_dq_o` with `nand_dq_oe_o` high.
- R4: A write to the address register runs one such write-strobe cycle with ALE high and CLE low.
- R5: A write to the data register runs a write-strobe cycle with both latch lines low. A read of the data register runs a cycle that pulses `nand_re_no` low with `nand_dq_oe_o` low throughout. It samples `nand_dq_i` at the last clock of the strobe and returns the byte in bits [7:0], with bits [31:8] zero.
- R6: In the timing register, write ready-wait is at [31:28], write width at [27:24], write hold at [23:20] and write setup at [19:16]. The read fields sit at the same positions in [15:0]. Setup (chip enable low, strobe high), width (strobe low) and hold (strobe high, bus still driven) each last their field value in clocks, and a value of 0 counts as 1. The fields are taken when the cycle starts.
- R7: After the hold phase the controller stays busy for the ready-wait count of that cycle's direction, which may be 0. Every register access except a control-register write is acknowledged only once the controller is idle. Command, address and data writes are acknowledged in the cycle they are accepted.
- R8: A data-register read is acknowledged in the last clock of the hold phase of its own bus cycle, which is setup+width+hold clocks after it is accepted.
- R9: `nand_ce_no` is low during the setup, width and hold phases of every cycle and high otherwise, unless config bit 5 is set, which holds it low.
- R10: Status bit 0 shows `nand_rb_i` after a two-flop synchroniser whose flops reset to 1 (ready). The other status bits read 0.
- R11: Event status bit 0 sets on a rising edge of the synchronised ready signal, but not on a falling edge or a steady level. Bit 1 sets at the end of every bus cycle's hold phase. Writing 1s to the event clear register clears the matching bits.
- R12: `irq_o` is high exactly when some event status bit is set and its event enable bit is set.
- R13: Writing a 1 to control bit 2 is accepted even while a cycle runs. It returns the sequencer to idle at once, with the pins idle and the controller no longer busy, and it clears the event status. Config, enable and timing keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request, held until acknowledged |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (4) | Register word index |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access completes at this clock edge |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| irq_o | output | 1 | Interrupt request |
| nand_ce_no | output | 1 | Flash chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven toward the flash |
| nand_dq_oe_o | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Byte returned by the flash |
| nand_rb_i | input | 1 | Flash ready (1) / busy (0) pin |

## Verification
The hardest case to reach is the software reset that lands in the middle of a long bus cycle. Every other access stalls while the sequencer is busy, so only the control register can get in. The bench programs all timing fields to 15, starts a command cycle and writes the control register right after. It then checks the acknowledge latency, the chip-enable release and the cleared event status. Random timing words, including the all-zero word where every phase shrinks to one clock, are combined with all four cycle kinds. For each one the bench measures the phase lengths on the pins and checks the stall seen by the next access.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
  localparam int unsigned TF_W = 4;

  localparam int unsigned REG_DATA   = 0;
  localparam int unsigned REG_ADDR   = 1;
  localparam int unsigned REG_CMD    = 2;
  localparam int unsigned REG_CTRL   = 4;
  localparam int unsigned REG_CFG    = 5;
  localparam int unsigned REG_STAT   = 6;
  localparam int unsigned REG_EVT    = 7;
  localparam int unsigned REG_EVTEN  = 8;
  localparam int unsigned REG_EVTCLR = 10;
  localparam int unsigned REG_TIMING = 11;

  localparam int unsigned CFG_CE_BIT   = 5;
  localparam int unsigned CTRL_RST_BIT = 2;
  localparam int unsigned N_EVT        = 2;
  localparam int unsigned CFG_W        = 6;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_WIDTH, PH_HOLD, PH_WAIT} phase_e;
  typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_WR, OP_RD} op_e;

  // field order is fixed by the timing register layout
  typedef struct packed {
    logic [TF_W-1:0] rdy;
    logic [TF_W-1:0] width;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] setup;
  } dir_timing_t;
endpackage

// File: rtl/nfc_sync.sv
`timescale 1ns/1ps
module nfc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_seq.sv
`timescale 1ns/1ps
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [DW-1:0] byte_i,
  input  dir_timing_t   wr_tim_i,
  input  dir_timing_t   rd_tim_i,
  input  logic [DW-1:0] dq_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cyc_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_no,
  output logic          re_no,
  output logic          dq_oe_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rd_byte_o
);
  phase_e          ph_q;
  logic [TF_W-1:0] cnt_q;
  op_e             op_q;
  logic [DW-1:0]   byte_q;
  logic [DW-1:0]   rd_q;
  dir_timing_t     tim_q;
  dir_timing_t     tim_sel;
  logic            last;

  // a zero field still yields one clock
  function automatic logic [TF_W-1:0] load(input logic [TF_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  assign tim_sel = (op_i == OP_RD) ? rd_tim_i : wr_tim_i;
  assign last    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      op_q   <= OP_CMD;
      byte_q <= '0;
      rd_q   <= '0;
      tim_q  <= '0;
    end else if (soft_rst_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          op_q   <= op_i;
          byte_q <= byte_i;
          tim_q  <= tim_sel;
          cnt_q  <= load(tim_sel.setup);
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_WIDTH;
          cnt_q <= load(tim_q.width);
        end else cnt_q <= cnt_q - 1'b1;
        PH_WIDTH: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= load(tim_q.hold);
          if (op_q == OP_RD) rd_q <= dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) begin
          if (tim_q.rdy == '0) ph_q <= PH_IDLE;
          else begin
            ph_q  <= PH_WAIT;
            cnt_q <= tim_q.rdy - 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_WAIT: if (last) ph_q <= PH_IDLE;
                 else      cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign cyc_o     = (ph_q == PH_SETUP) || (ph_q == PH_WIDTH) || (ph_q == PH_HOLD);
  assign done_o    = (ph_q == PH_HOLD) && last;
  assign cle_o     = cyc_o && (op_q == OP_CMD);
  assign ale_o     = cyc_o && (op_q == OP_ADR);
  assign we_no     = !((ph_q == PH_WIDTH) && (op_q != OP_RD));
  assign re_no     = !((ph_q == PH_WIDTH) && (op_q == OP_RD));
  assign dq_oe_o   = cyc_o && (op_q != OP_RD);
  assign dq_o      = dq_oe_o ? byte_q : '0;
  assign rd_byte_o = rd_q;
endmodule

// File: rtl/nfc_regs.sv
`timescale 1ns/1ps
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned RW = 32,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] wdata_i,
  output logic          ack_o,
  output logic [RW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] rd_byte_i,
  input  logic          rb_sync_i,
  output logic          start_o,
  output op_e           op_o,
  output logic [DW-1:0] byte_o,
  output dir_timing_t   wr_tim_o,
  output dir_timing_t   rd_tim_o,
  output logic          ce_force_o,
  output logic          soft_rst_o,
  output logic          irq_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [N_EVT-1:0] evt_q, evt_en_q, evt_set, evt_clr;
  logic [RW-1:0]    tim_q;
  logic             pend_q, rb_prev_q;
  logic             is_ctrl, is_drd, is_launch_wr, accept, launch_rd, wr_acc;

  assign is_ctrl      = (addr_i == AW'(REG_CTRL));
  assign is_drd       = (addr_i == AW'(REG_DATA)) && !we_i;
  assign is_launch_wr = we_i && ((addr_i == AW'(REG_DATA)) ||
                                 (addr_i == AW'(REG_ADDR)) ||
                                 (addr_i == AW'(REG_CMD)));

  // control writes bypass the busy stall so a reset can abort a cycle
  assign accept    = req_i && !pend_q && !is_drd && (!busy_i || (is_ctrl && we_i));
  assign launch_rd = req_i && !pend_q && !busy_i && is_drd;
  assign wr_acc    = accept && we_i;
  assign ack_o     = accept || (pend_q && done_i);

  assign start_o    = (accept && is_launch_wr) || launch_rd;
  assign byte_o     = wdata_i[DW-1:0];
  assign soft_rst_o = wr_acc && is_ctrl && wdata_i[CTRL_RST_BIT];

  always_comb begin
    if (launch_rd)                          op_o = OP_RD;
    else if (addr_i == AW'(REG_CMD))        op_o = OP_CMD;
    else if (addr_i == AW'(REG_ADDR))       op_o = OP_ADR;
    else                                    op_o = OP_WR;
  end

  assign evt_set = {done_i, rb_sync_i && !rb_prev_q};
  assign evt_clr = (wr_acc && addr_i == AW'(REG_EVTCLR)) ? wdata_i[N_EVT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      evt_q     <= '0;
      evt_en_q  <= '0;
      tim_q     <= '0;
      pend_q    <= 1'b0;
      rb_prev_q <= 1'b1;
    end else begin
      rb_prev_q <= rb_sync_i;
      if (soft_rst_o) begin
        evt_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        evt_q <= (evt_q & ~evt_clr) | evt_set;
        if (launch_rd)            pend_q <= 1'b1;
        else if (pend_q && done_i) pend_q <= 1'b0;
      end
      if (wr_acc && addr_i == AW'(REG_CFG))    cfg_q    <= wdata_i[CFG_W-1:0];
      if (wr_acc && addr_i == AW'(REG_EVTEN))  evt_en_q <= wdata_i[N_EVT-1:0];
      if (wr_acc && addr_i == AW'(REG_TIMING)) tim_q    <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(REG_DATA):   rdata_o[DW-1:0]    = rd_byte_i;
      AW'(REG_CFG):    rdata_o[CFG_W-1:0] = cfg_q;
      AW'(REG_STAT):   rdata_o[0]         = rb_sync_i;
      AW'(REG_EVT):    rdata_o[N_EVT-1:0] = evt_q;
      AW'(REG_EVTEN):  rdata_o[N_EVT-1:0] = evt_en_q;
      AW'(REG_TIMING): rdata_o            = tim_q;
      default:         rdata_o            = '0;
    endcase
  end

  assign wr_tim_o   = dir_timing_t'(tim_q[RW-1:RW/2]);
  assign rd_tim_o   = dir_timing_t'(tim_q[RW/2-1:0]);
  assign ce_force_o = cfg_q[CFG_CE_BIT];
  assign irq_o      = |(evt_q & evt_en_q);
endmodule

// File: rtl/nand_bus_ctrl.sv
`timescale 1ns/1ps
module nand_bus_ctrl
  import nfc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              ack_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [BUS_W-1:0]  nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [BUS_W-1:0]  nand_dq_i,
  input  logic              nand_rb_i
);
  logic             rb_sync, busy, done, cyc, start, ce_force, soft_rst;
  op_e              op;
  logic [BUS_W-1:0] wr_byte, rd_byte;
  dir_timing_t      wr_tim, rd_tim;

  nfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (nand_rb_i), .q_o (rb_sync)
  );

  nfc_regs #(.AW(ADDR_W), .RW(REG_W), .DW(BUS_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .busy_i     (busy),
    .done_i     (done),
    .rd_byte_i  (rd_byte),
    .rb_sync_i  (rb_sync),
    .start_o    (start),
    .op_o       (op),
    .byte_o     (wr_byte),
    .wr_tim_o   (wr_tim),
    .rd_tim_o   (rd_tim),
    .ce_force_o (ce_force),
    .soft_rst_o (soft_rst),
    .irq_o      (irq_o)
  );

  nfc_seq #(.DW(BUS_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .start_i    (start),
    .op_i       (op),
    .byte_i     (wr_byte),
    .wr_tim_i   (wr_tim),
    .rd_tim_i   (rd_tim),
    .dq_i       (nand_dq_i),
    .busy_o     (busy),
    .done_o     (done),
    .cyc_o      (cyc),
    .cle_o      (nand_cle_o),
    .ale_o      (nand_ale_o),
    .we_no      (nand_we_no),
    .re_no      (nand_re_no),
    .dq_oe_o    (nand_dq_oe_o),
    .dq_o       (nand_dq_o),
    .rd_byte_o  (rd_byte)
  );

  assign nand_ce_no = !(ce_force || cyc);
endmodule

// File: rtl/nfc_checker.sv
`timescale 1ns/1ps
module nfc_checker #(
  parameter int unsigned BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ack_o,
  input logic             nand_ce_no,
  input logic             nand_cle_o,
  input logic             nand_ale_o,
  input logic             nand_we_no,
  input logic             nand_re_no,
  input logic [BUS_W-1:0] nand_dq_o,
  input logic             nand_dq_oe_o
);
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no)); // R5

  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o); // R5

  AST_STROBE_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no); // R9

  AST_WE_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_we_no) |-> $past(!nand_ce_no && nand_dq_oe_o)); // R6

  AST_WR_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no && $past(!nand_we_no)) |-> $stable(nand_dq_o)); // R6

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_i); // R7
endmodule

bind nand_bus_ctrl nfc_checker #(.BUS_W(BUS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ack_o        (ack_o),
  .nand_ce_no   (nand_ce_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_dq_o    (nand_dq_o),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/tb_nand_bus_ctrl.sv
`timescale 1ns/1ps
module tb_nand_bus_ctrl;
  localparam logic [3:0] A_DATA = 0, A_ADDR = 1, A_CMD = 2, A_GAP = 3, A_CTRL = 4,
                         A_CFG = 5, A_STAT = 6, A_EVT = 7, A_EN = 8, A_GAP2 = 9,
                         A_CLR = 10, A_TIM = 11, A_GAP3 = 13;

  logic clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0, nand_rb_i = 1;
  logic [3:0] addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic [7:0] nand_dq_i = 0, nand_dq_o;
  logic ack_o, irq_o, nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_dq_oe_o;

  int n_chk = 0, n_fail = 0;

  nand_bus_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  // pin monitor: measures phase lengths of each chip-enable window
  int s_c, w_c, h_c, ev_cnt = 0;
  logic in_c = 0, stb_seen, m_cle, m_ale, m_rd, m_oe;
  logic [7:0] m_b;
  always @(negedge clk_i) begin
    if (rst_ni && !nand_ce_no) begin
      if (!in_c) begin in_c = 1; s_c = 0; w_c = 0; h_c = 0; stb_seen = 0; m_oe = 0; end
      m_cle = nand_cle_o; m_ale = nand_ale_o; m_oe = m_oe | nand_dq_oe_o;
      if (!nand_we_no || !nand_re_no) begin
        if (!stb_seen) begin m_rd = !nand_re_no; m_b = nand_dq_o; end
        stb_seen = 1; w_c++;
      end else if (stb_seen) h_c++;
      else s_c++;
    end else if (in_c) begin
      in_c = 0; ev_cnt++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int waits);
    req_i = 1; we_i = w; addr_i = a; wdata_i = d;
    #1; waits = 0;
    while (!ack_o && waits < 2000) begin @(negedge clk_i); #1; waits++; end
    if (!ack_o) begin n_chk++; n_fail++; $display("FAIL R7 bus hang actual=%0d expected=<2000", waits); end
    q = rdata_o;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  function automatic int ln(input logic [3:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] q, q2, tim;
    logic [15:0] dt;
    logic [7:0] b;
    int w1, w2, op, e0, S, W, H, R;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 pins", {nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_dq_oe_o, irq_o},
        7'b1001100);
    bus(0, A_TIM, 0, q, w1); chk("R1 timing", q, 0);
    bus(0, A_CFG, 0, q, w1); chk("R1 cfg", q, 0);
    bus(0, A_EN, 0, q, w1);  chk("R1 enable", q, 0);
    bus(0, A_EVT, 0, q, w1); chk("R1 events", q, 0);
    bus(0, A_STAT, 0, q, w1); chk("R10 status after reset", q, 1);

    // R2 readback and holes
    bus(1, A_TIM, 32'hA5C3_1E7F, q, w1); bus(0, A_TIM, 0, q, w1); chk("R2 timing readback", q, 32'hA5C3_1E7F);
    bus(1, A_CFG, 32'hFFFF_FFDF, q, w1); bus(0, A_CFG, 0, q, w1); chk("R2 cfg readback", q, 32'h1F);
    bus(1, A_EN, 32'hFFFF_FFFE, q, w1);  bus(0, A_EN, 0, q, w1);  chk("R2 enable readback", q, 2);
    bus(1, A_EN, 0, q, w1); bus(1, A_CFG, 0, q, w1);
    bus(0, A_GAP, 0, q, w1);  chk("R2 hole 3", q, 0);
    bus(0, A_GAP2, 0, q, w1); chk("R2 hole 9", q, 0);
    bus(0, A_GAP3, 0, q, w1); chk("R2 hole 13", q, 0);

    // random cycles against phase, latch, data and stall expectations (R3..R8)
    for (int i = 0; i < 80; i++) begin
      tim = $urandom;
      if (i == 0) tim = 0;
      if (i == 1) tim = 32'hFFFF_FFFF;
      op = (i < 8) ? (i % 4) : int'($urandom_range(0, 3));
      b = 8'($urandom);
      bus(1, A_TIM, tim, q, w1);
      nand_dq_i = (op == 3) ? b : 8'($urandom);
      dt = (op == 3) ? tim[15:0] : tim[31:16];
      S = ln(dt[3:0]); H = ln(dt[7:4]); W = ln(dt[11:8]); R = int'(dt[15:12]);
      e0 = ev_cnt;
      case (op)
        0: bus(1, A_CMD,  {24'hC0FFEE, b}, q, w1);
        1: bus(1, A_ADDR, {24'h123456, b}, q, w1);
        2: bus(1, A_DATA, {24'hBADBAD, b}, q, w1);
        default: bus(0, A_DATA, 0, q, w1);
      endcase
      bus(0, A_STAT, 0, q2, w2);
      chk("R3 one cycle per access", ev_cnt - e0, 1);
      chk("R6 setup clocks", s_c, S);
      chk("R6 width clocks", w_c, W);
      chk("R6 hold clocks", h_c, H);
      chk("R3 cle", m_cle, op == 0);
      chk("R4 ale", m_ale, op == 1);
      chk("R5 strobe kind", m_rd, op == 3);
      chk("R5 bus drive", m_oe, op != 3);
      if (op == 3) begin
        chk("R5 read data", q, {24'h0, b});
        chk("R8 read ack latency", w1, S + W + H);
        chk("R7 stall after read", w2, R);
      end else begin
        chk("R3 byte on bus", m_b, b);
        chk("R7 write ack", w1, 0);
        chk("R7 stall after write", w2, S + W + H + R);
      end
    end

    // R9 chip-enable forcing
    bus(1, A_CFG, 32'h20, q, w1); @(negedge clk_i);
    chk("R9 forced ce", nand_ce_no, 0);
    bus(1, A_CFG, 0, q, w1); @(negedge clk_i);
    chk("R9 released ce", nand_ce_no, 1);

    // R11 cycle-done event, R12 gating
    bus(1, A_CLR, 3, q, w1); bus(0, A_EVT, 0, q, w1); chk("R11 clear", q, 0);
    bus(1, A_TIM, 0, q, w1);
    bus(1, A_CMD, 8'h70, q, w1);
    bus(0, A_EVT, 0, q, w1); chk("R11 done event", q, 2);
    chk("R12 irq masked", irq_o, 0);
    bus(1, A_EN, 2, q, w1); chk("R12 irq enabled", irq_o, 1);
    bus(1, A_EN, 1, q, w1); chk("R12 irq other bit", irq_o, 0);
    bus(1, A_CLR, 2, q, w1); bus(0, A_EVT, 0, q, w1); chk("R11 clear done", q, 0);

    // R10/R11 ready synchroniser and edge event
    nand_rb_i = 0; repeat (3) @(negedge clk_i);
    bus(0, A_STAT, 0, q, w1); chk("R10 busy level", q, 0);
    bus(0, A_EVT, 0, q, w1);  chk("R11 no event on fall", q, 0);
    chk("R12 irq low", irq_o, 0);
    nand_rb_i = 1; repeat (4) @(negedge clk_i);
    bus(0, A_STAT, 0, q, w1); chk("R10 ready level", q, 1);
    bus(0, A_EVT, 0, q, w1);  chk("R11 rise event", q, 1);
    chk("R12 irq from ready", irq_o, 1);
    bus(1, A_CLR, 1, q, w1); repeat (4) @(negedge clk_i);
    bus(0, A_EVT, 0, q, w1);  chk("R11 steady level no event", q, 0);
    chk("R12 irq after clear", irq_o, 0);

    // R13 soft reset aborts a long cycle
    bus(1, A_EN, 3, q, w1);
    bus(1, A_TIM, 32'hFFFF_FFFF, q, w1);
    bus(1, A_CMD, 8'h90, q, w1);
    chk("R9 ce low in cycle", nand_ce_no, 0);
    bus(1, A_CTRL, 4, q, w1);
    chk("R13 ctrl not stalled", w1, 0);
    chk("R13 pins idle", {nand_ce_no, nand_cle_o, nand_we_no, nand_dq_oe_o}, 4'b1010);
    bus(0, A_STAT, 0, q, w1); chk("R13 not busy", w1, 0);
    bus(0, A_EVT, 0, q, w1);  chk("R13 events cleared", q, 0);
    bus(0, A_TIM, 0, q, w1);  chk("R13 timing kept", q, 32'hFFFF_FFFF);
    bus(0, A_EN, 0, q, w1);   chk("R13 enable kept", q, 3);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule